// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a serial keyboard byte receiver, which hands it one 8-bit scan code byte per strobe. It folds the two prefix bytes of scan code set 2 (0xE0 for extended keys, 0xF0 for key release) into flags on a single key event. The event holds the key code, an extended flag, a released flag and a small ASCII translation. The block also keeps the state of both shift keys, so letters translate in uppercase while either shift is held.

A consumer sees `ev_ready` and reads the event fields. It then pulses `ev_read` to clear the ready flag. If a new event arrives before the old one is taken, the new event replaces it. The parameter `HIDE_SHIFT` turns shift keys into pure state changes: they update `shift_on` but raise no event.

Top module: `kbd_event_decoder`

## Requirements
- R1: A byte of 0xE0 raises no event. It marks the next event as extended (`ev_ext`=1).
- R2: A byte of 0xF0 raises no event. It marks the next event as released (`ev_rel`=1).
- R3: Any other byte raises an event with `ev_code` equal to that byte. The event carries the prefix flags gathered since the last non-prefix byte. Every non-prefix byte clears both flags, whether or not it raises an event.
- R4: A non-extended 0x12 (left shift) or 0x59 (right shift) sets that key's held bit on press and clears it on release. `shift_on` is the OR of the two held bits. An extended 0x12 or 0x59 leaves the shift state unchanged.
- R5: With `HIDE_SHIFT`=1, non-extended shift presses and releases raise no event, but they still update `shift_on` and clear the prefix flags.
- R6: With `HIDE_SHIFT`=0, shift bytes raise events like any other key, with `ev_ascii`=0x00.
- R7: Letter codes translate to lowercase ASCII while `shift_on` is 0 and to uppercase while it is 1. The translation applies to press and release events alike (for example 0x1C gives 0x61 or 0x41, and 0x3B gives 0x6A or 0x4A).
- R8: The following codes translate the same way whatever the shift state:
  - digits: 0x45 gives 0x30, 0x16 gives 0x31, 0x1E gives 0x32, and so on;
  - space: 0x29 gives 0x20;
  - enter: 0x5A gives 0x0D;
  - tab: 0x0D gives 0x09.
- R9: Extended events, and codes with no mapping, give `ev_ascii`=0x00.
- R10: `ev_ready` rises in the cycle after the byte that raises an event. It stays high until `ev_read` is sampled high, and it falls in the following cycle. A new event in the same cycle as `ev_read` keeps it high.
- R11: A new event while `ev_ready` is high overwrites all event fields.
- R12: Reset clears `ev_ready`, the prefix flags, the shift state and the event fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Strobe: `byte_in` holds a received byte |
| byte_in | input | 8 | Received scan code byte |
| ev_read | input | 1 | Consumer acknowledge of the held event |
| ev_ready | output | 1 | An event is held |
| ev_code | output | 8 | Key code of the event |
| ev_ext | output | 1 | Event was preceded by 0xE0 |
| ev_rel | output | 1 | Event was preceded by 0xF0 |
| ev_ascii | output | 8 | ASCII translation, 0x00 if none |
| shift_on | output | 1 | Either shift key is held |

## Verification
The hardest case to reach is a hidden shift byte that sits between a prefix and the next key. From the ports it produces no event at all, so it shows only through the flags of the event that follows it. The stimulus sends a release prefix and then a hidden shift, and checks that the next letter arrives unreleased and in lowercase. The extended shift case is also covered: an extended 0x12 must raise an event without changing the case of later letters.

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder #(
  parameter bit         HIDE_SHIFT  = 1'b0,
  parameter logic [7:0] EXT_PREFIX  = 8'hE0,
  parameter logic [7:0] REL_PREFIX  = 8'hF0,
  parameter logic [7:0] LSHIFT_CODE = 8'h12,
  parameter logic [7:0] RSHIFT_CODE = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       ev_read,
  output logic       ev_ready,
  output logic [7:0] ev_code,
  output logic       ev_ext,
  output logic       ev_rel,
  output logic [7:0] ev_ascii,
  output logic       shift_on
);

  logic ext_q, rel_q, lsh_q, rsh_q;

  wire is_ext   = byte_in == EXT_PREFIX;
  wire is_rel   = byte_in == REL_PREFIX;
  wire is_lsh   = !ext_q && byte_in == LSHIFT_CODE;
  wire is_rsh   = !ext_q && byte_in == RSHIFT_CODE;
  wire key_byte = byte_valid && !is_ext && !is_rel;
  wire emit     = key_byte && !(HIDE_SHIFT && (is_lsh || is_rsh));

  assign shift_on = lsh_q | rsh_q;

  function automatic logic [7:0] to_ascii(input logic [7:0] c, input logic up);
    logic [7:0] ch;
    logic       letter;
    letter = 1'b1;
    case (c)
      8'h1C: ch = "A";  8'h32: ch = "B";  8'h21: ch = "C";  8'h23: ch = "D";
      8'h24: ch = "E";  8'h2B: ch = "F";  8'h34: ch = "G";  8'h33: ch = "H";
      8'h43: ch = "I";  8'h3B: ch = "J";  8'h42: ch = "K";  8'h4B: ch = "L";
      8'h3A: ch = "M";  8'h31: ch = "N";  8'h44: ch = "O";  8'h4D: ch = "P";
      8'h15: ch = "Q";  8'h2D: ch = "R";  8'h1B: ch = "S";  8'h2C: ch = "T";
      8'h3C: ch = "U";  8'h2A: ch = "V";  8'h1D: ch = "W";  8'h22: ch = "X";
      8'h35: ch = "Y";  8'h1A: ch = "Z";
      default: begin
        letter = 1'b0;
        case (c)
          8'h45: ch = "0";  8'h16: ch = "1";  8'h1E: ch = "2";  8'h26: ch = "3";
          8'h25: ch = "4";  8'h2E: ch = "5";  8'h36: ch = "6";  8'h3D: ch = "7";
          8'h3E: ch = "8";  8'h46: ch = "9";
          8'h29: ch = 8'h20;
          8'h5A: ch = 8'h0D;
          8'h0D: ch = 8'h09;
          default: ch = 8'h00;
        endcase
      end
    endcase
    if (letter && !up) ch = ch | 8'h20;
    return ch;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= 1'b0;
      rel_q    <= 1'b0;
      lsh_q    <= 1'b0;
      rsh_q    <= 1'b0;
      ev_ready <= 1'b0;
      ev_code  <= 8'h00;
      ev_ext   <= 1'b0;
      ev_rel   <= 1'b0;
      ev_ascii <= 8'h00;
    end else begin
      if (byte_valid && is_ext) ext_q <= 1'b1;
      if (byte_valid && is_rel) rel_q <= 1'b1;
      if (key_byte) begin
        ext_q <= 1'b0;
        rel_q <= 1'b0;
        if (is_lsh) lsh_q <= !rel_q;
        if (is_rsh) rsh_q <= !rel_q;
      end
      if (emit) begin
        ev_ready <= 1'b1;
        ev_code  <= byte_in;
        ev_ext   <= ext_q;
        ev_rel   <= rel_q;
        ev_ascii <= ext_q ? 8'h00 : to_ascii(byte_in, shift_on);
      end else if (ev_read) begin
        ev_ready <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/kbd_event_decoder_chk.sv
module kbd_event_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [7:0] byte_in,
  input logic       ev_read,
  input logic       ev_ready,
  input logic [7:0] ev_code,
  input logic       ev_ext,
  input logic       ev_rel,
  input logic [7:0] ev_ascii,
  input logic       shift_on
);

  assert_prefix_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && (byte_in == 8'hE0 || byte_in == 8'hF0) && !ev_ready) |=> !ev_ready);

  assert_ready_from_byte_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_ready) |-> $past(byte_valid));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_read && !byte_valid) |=> !ev_ready);

  assert_hold_event_R11: assert property (@(posedge clk) disable iff (rst)
    (ev_ready && !byte_valid && !ev_read) |=> (ev_ready && $stable(ev_code) && $stable(ev_ascii)));

  assert_shift_needs_byte_R4: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(shift_on));

  assert_ext_no_ascii_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_ready && ev_ext) |-> ev_ascii == 8'h00);

endmodule

bind kbd_event_decoder kbd_event_decoder_chk u_chk (.*);

// File: tb/test_kbd_event_decoder.sv
module test_kbd_event_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       ev_read = 1'b0;

  logic       ev_ready, ev_ext, ev_rel, shift_on;
  logic [7:0] ev_code, ev_ascii;
  logic       h_ready, h_ext, h_rel, h_shift;
  logic [7:0] h_code, h_ascii;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  kbd_event_decoder i_kbd_event_decoder (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in), .ev_read(ev_read),
    .ev_ready(ev_ready), .ev_code(ev_code), .ev_ext(ev_ext), .ev_rel(ev_rel),
    .ev_ascii(ev_ascii), .shift_on(shift_on));

  kbd_event_decoder #(.HIDE_SHIFT(1'b1)) i_kbd_event_decoder_hide (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in), .ev_read(ev_read),
    .ev_ready(h_ready), .ev_code(h_code), .ev_ext(h_ext), .ev_rel(h_rel),
    .ev_ascii(h_ascii), .shift_on(h_shift));

  // row: byte[19:12] event[11] ext[10] rel[9] shift[8] ascii[7:0]
  localparam int NROWS = 34;
  localparam logic [19:0] ROWS [NROWS] = '{
    {8'h1C,1'b1,1'b0,1'b0,1'b0,8'h61},
    {8'hF0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'h1C,1'b1,1'b0,1'b1,1'b0,8'h61},
    {8'h12,1'b1,1'b0,1'b0,1'b1,8'h00},
    {8'h1C,1'b1,1'b0,1'b0,1'b1,8'h41},
    {8'hF0,1'b0,1'b0,1'b0,1'b1,8'h00},
    {8'h12,1'b1,1'b0,1'b1,1'b0,8'h00},
    {8'h1C,1'b1,1'b0,1'b0,1'b0,8'h61},
    {8'h59,1'b1,1'b0,1'b0,1'b1,8'h00},
    {8'h16,1'b1,1'b0,1'b0,1'b1,8'h31},
    {8'h0D,1'b1,1'b0,1'b0,1'b1,8'h09},
    {8'hF0,1'b0,1'b0,1'b0,1'b1,8'h00},
    {8'h59,1'b1,1'b0,1'b1,1'b0,8'h00},
    {8'hE0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'h11,1'b1,1'b1,1'b0,1'b0,8'h00},
    {8'h11,1'b1,1'b0,1'b0,1'b0,8'h00},
    {8'hE0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'hF0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'h11,1'b1,1'b1,1'b1,1'b0,8'h00},
    {8'h29,1'b1,1'b0,1'b0,1'b0,8'h20},
    {8'h5A,1'b1,1'b0,1'b0,1'b0,8'h0D},
    {8'hE0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'h5A,1'b1,1'b1,1'b0,1'b0,8'h00},
    {8'hE0,1'b0,1'b0,1'b0,1'b0,8'h00},
    {8'h12,1'b1,1'b1,1'b0,1'b0,8'h00},
    {8'h1C,1'b1,1'b0,1'b0,1'b0,8'h61},
    {8'h45,1'b1,1'b0,1'b0,1'b0,8'h30},
    {8'h3B,1'b1,1'b0,1'b0,1'b0,8'h6A},
    {8'h12,1'b1,1'b0,1'b0,1'b1,8'h00},
    {8'h3B,1'b1,1'b0,1'b0,1'b1,8'h4A},
    {8'h1E,1'b1,1'b0,1'b0,1'b1,8'h32},
    {8'hF0,1'b0,1'b0,1'b0,1'b1,8'h00},
    {8'h12,1'b1,1'b0,1'b1,1'b0,8'h00},
    {8'h76,1'b1,1'b0,1'b0,1'b0,8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk);
    ev_read = 1'b1;
    @(negedge clk);
    ev_read = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset ready", ev_ready, 0);
    chk("R12 reset code", ev_code, 0);
    chk("R12 reset shift", shift_on, 0);

    for (int i = 0; i < NROWS; i++) begin
      logic [19:0] r;
      r = ROWS[i];
      send(r[19:12]);
      chk("R4 shift_on", shift_on, r[8]);
      if (r[11]) begin
        chk("R3 ready", ev_ready, 1);
        chk("R3 code", ev_code, r[19:12]);
        chk("R1 ext", ev_ext, r[10]);
        chk("R2 rel", ev_rel, r[9]);
        chk("R7 R8 R9 R6 ascii", ev_ascii, r[7:0]);
        pulse_read();
        chk("R10 read clears", ev_ready, 0);
      end else begin
        chk("R1 R2 prefix no event", ev_ready, 0);
      end
    end

    do_reset();
    send(8'h1C);
    send(8'h29);
    chk("R11 overwrite code", ev_code, 8'h29);
    chk("R11 overwrite ascii", ev_ascii, 8'h20);
    chk("R11 still ready", ev_ready, 1);
    @(negedge clk);
    ev_read = 1'b1;
    byte_valid = 1'b1;
    byte_in = 8'h16;
    @(negedge clk);
    ev_read = 1'b0;
    byte_valid = 1'b0;
    chk("R10 event beats read", ev_ready, 1);
    chk("R10 event beats read code", ev_code, 8'h16);
    pulse_read();

    send(8'hE0);
    do_reset();
    send(8'h1C);
    chk("R12 prefix cleared by reset", ev_ext, 0);
    send(8'h12);
    chk("R12 pre shift", shift_on, 1);
    do_reset();
    chk("R12 shift cleared", shift_on, 0);
    chk("R12 ready cleared", ev_ready, 0);

    send(8'h12);
    chk("R5 hidden press no event", h_ready, 0);
    chk("R5 hidden press shift", h_shift, 1);
    chk("R6 visible shift event", ev_ready, 1);
    send(8'h1C);
    chk("R5 hidden upper", h_ascii, 8'h41);
    pulse_read();
    send(8'hF0);
    send(8'h12);
    chk("R5 hidden release no event", h_ready, 0);
    chk("R5 hidden release shift", h_shift, 0);
    send(8'h1C);
    chk("R5 rel flag cleared by hidden", h_rel, 0);
    chk("R5 lower after release", h_ascii, 8'h61);
    chk("R5 code", h_code, 8'h1C);
    pulse_read();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule